// File: doc/BRIEF.md
# Register-Pointer Serial Slave

This block is a two-wire serial bus slave. Through it an external master reaches a bank of 8-bit registers that sits outside the block. The clock line and the data line come in asynchronously. Each passes through a synchroniser into the system clock domain, and edge detection there finds START and STOP conditions and clock edges. The slave answers a fixed 7-bit bus address. It drives the data line only as an open-drain pull-down enable.

A write transaction stores its first byte in an internal pointer. If a second byte follows, it goes to the register the pointer selects, as a one-cycle write strobe with the address and the data. A read transaction sends no pointer. It returns one byte, fetched from the register bank at the pointer that an earlier write left behind. The pointer never advances on its own, and a single transaction cannot mix a write and a read.

Top module: `regptr_slave`

## Requirements
- R1: Every byte on the bus takes nine clock pulses: eight data bits, most significant first, sampled while the clock line is high, then one acknowledge bit. Acknowledge means the data line is low during the ninth pulse.
- R2: The slave changes its data-line drive only while the clock line is low.
- R3: The slave acknowledges the first byte after START only when bits 7..1 equal `SLAVE_ADDR`. On a mismatch it acknowledges nothing and drives nothing until the next START. Bit 0 selects the direction: 1 is read, 0 is write.
- R4: In a write, the first byte after the address is acknowledged and loaded into the pointer (`rdAddr`). A STOP right after it changes the pointer and nothing else: `wrEn` stays low.
- R5: A second write byte is acknowledged and produces exactly one cycle of `wrEn`, with `wrAddr` equal to the pointer and `wrData` equal to the byte.
- R6: Bytes after the second in a write are not acknowledged, produce no `wrEn`, and leave the pointer unchanged (no auto-increment).
- R7: A read returns `rdData` for the pointer, MSB first, as exactly one byte. The slave releases the data line during the master's acknowledge slot and after it.
- R8: A START at any point, even in the middle of a byte, restarts address reception with a fresh bit count.
- R9: A STOP ends the transaction, and the slave's data-line drive is off in the cycle after it is detected.
- R10: After reset `sdaOe` is 0, the pointer is 0 and `wrEn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level (asynchronous) |
| sdaIn | input | 1 | Serial data line level (asynchronous) |
| sdaOe | output | 1 | 1 pulls the data line low |
| rdAddr | output | 8 | Current pointer, the address presented to the register bank |
| rdData | input | 8 | Register bank contents at `rdAddr` |
| wrEn | output | 1 | One-cycle register write strobe |
| wrAddr | output | 8 | Write address, valid with `wrEn` |
| wrData | output | 8 | Write data, valid with `wrEn` |

## Verification
The bench targets four cases. A STOP right after the pointer byte would give a design that always commits the data phase a spurious write strobe. A third write byte would show an auto-incrementing or over-eager design acknowledging it or writing it to the next address. A START in the middle of a byte would leave a design without a fresh bit count misaligned, so it would miss the following address acknowledge. On reads, the bench checks that the data line is free during the master's No-Acknowledge slot, where a design that kept shifting would pull the line low, and that a mismatched address never pulls the line low.

// File: rtl/regptr_pkg.sv
package regptr_pkg;
  localparam int BYTE_W     = 8;
  localparam int FRAME_BITS = BYTE_W + 1;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic rxShift;
    logic ptrLoad;
    logic regWrite;
    logic txLoad;
    logic txShift;
    logic oeAck;
    logic oeRelease;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_READ
  } busState_t;
endpackage

// File: rtl/rp_line_sync.sv
module rp_line_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineLvl,
  output logic lineRise,
  output logic lineFall
);
  logic [STAGES-1:0] pipe;
  logic              prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipe    <= {STAGES{RESET_VAL}};
      prevLvl <= RESET_VAL;
    end else begin
      pipe    <= {pipe[STAGES-2:0], lineIn};
      prevLvl <= pipe[STAGES-1];
    end
  end

  assign lineLvl  = pipe[STAGES-1];
  assign lineRise = lineLvl & ~prevLvl;
  assign lineFall = ~lineLvl & prevLvl;
endmodule

// File: rtl/rp_control.sv
module rp_control
  import regptr_pkg::*;
#(
  parameter int               ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h4C,
  parameter int               CNT_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] rxByte,
  output ctrlStrobes_t      stb
);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(FRAME_BITS);

  busState_t state, nextState;
  logic      addrHit;
  logic      rwBit;

  assign addrHit = (rxByte[BYTE_W-1 -: ADDR_W] == SLAVE_ADDR);
  assign rwBit   = rxByte[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    if (startDet) begin
      stb.cntClr    = 1'b1;
      stb.oeRelease = 1'b1;
      nextState     = ST_ADDR;
    end else if (stopDet) begin
      stb.cntClr    = 1'b1;
      stb.oeRelease = 1'b1;
      nextState     = ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_DATA: begin
          if (sclRise) begin
            stb.cntInc  = 1'b1;
            stb.rxShift = (bitCnt < BYTE_END);
          end else if (sclFall && bitCnt == BYTE_END) begin
            if (state == ST_ADDR && !addrHit) begin
              stb.cntClr = 1'b1;
              nextState  = ST_IDLE;
            end else begin
              stb.oeAck    = 1'b1;
              stb.ptrLoad  = (state == ST_PTR);
              stb.regWrite = (state == ST_DATA);
            end
          end else if (sclFall && bitCnt == ACK_END) begin
            stb.cntClr    = 1'b1;
            stb.oeRelease = 1'b1;
            case (state)
              ST_ADDR: begin
                if (rwBit) begin
                  stb.txLoad = 1'b1;
                  nextState  = ST_READ;
                end else begin
                  nextState  = ST_PTR;
                end
              end
              ST_PTR:  nextState = ST_DATA;
              default: nextState = ST_IDLE;
            endcase
          end
        end
        ST_READ: begin
          if (sclRise) begin
            stb.cntInc = 1'b1;
          end else if (sclFall) begin
            if (bitCnt == ACK_END) begin
              stb.cntClr    = 1'b1;
              stb.oeRelease = 1'b1;
              nextState     = ST_IDLE;
            end else if (bitCnt == BYTE_END) begin
              stb.oeRelease = 1'b1;
            end else if (bitCnt != '0) begin
              stb.txShift = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rp_datapath.sv
module rp_datapath
  import regptr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic              sdaLvl,
  input  logic [BYTE_W-1:0] rdData,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] ptrReg,
  output logic              sdaOe,
  output logic              wrEn,
  output logic [BYTE_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData
);
  logic [BYTE_W-1:0] txReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
      ptrReg <= '0;
      txReg  <= '0;
      sdaOe  <= 1'b0;
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      if (stb.cntClr)      bitCnt <= '0;
      else if (stb.cntInc) bitCnt <= bitCnt + 1'b1;

      if (stb.rxShift) rxByte <= {rxByte[BYTE_W-2:0], sdaLvl};
      if (stb.ptrLoad) ptrReg <= rxByte;

      wrEn <= stb.regWrite;
      if (stb.regWrite) begin
        wrAddr <= ptrReg;
        wrData <= rxByte;
      end

      if (stb.txLoad)       txReg <= rdData;
      else if (stb.txShift) txReg <= {txReg[BYTE_W-2:0], txReg[BYTE_W-1]};

      if (stb.txLoad)         sdaOe <= ~rdData[BYTE_W-1];
      else if (stb.txShift)   sdaOe <= ~txReg[BYTE_W-2];
      else if (stb.oeAck)     sdaOe <= 1'b1;
      else if (stb.oeRelease) sdaOe <= 1'b0;
    end
  end
endmodule

// File: rtl/regptr_slave.sv
module regptr_slave
  import regptr_pkg::*;
#(
  parameter int               ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h4C,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [BYTE_W-1:0] rdAddr,
  input  logic [BYTE_W-1:0] rdData,
  output logic              wrEn,
  output logic [BYTE_W-1:0] wrAddr,
  output logic [BYTE_W-1:0] wrData
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic sclLvl, sclRise, sclFall;
  logic sdaLvl, sdaRise, sdaFall;
  logic startDet, stopDet;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxByte;
  ctrlStrobes_t      stb;

  rp_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .lineIn(sclIn),
    .lineLvl(sclLvl), .lineRise(sclRise), .lineFall(sclFall)
  );

  rp_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .lineIn(sdaIn),
    .lineLvl(sdaLvl), .lineRise(sdaRise), .lineFall(sdaFall)
  );

  assign startDet = sclLvl & sdaFall;
  assign stopDet  = sclLvl & sdaRise;

  rp_control #(.ADDR_W(ADDR_W), .SLAVE_ADDR(SLAVE_ADDR), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .sclFall(sclFall), .bitCnt(bitCnt),
    .rxByte(rxByte), .stb(stb)
  );

  rp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaLvl(sdaLvl), .rdData(rdData),
    .bitCnt(bitCnt), .rxByte(rxByte), .ptrReg(rdAddr), .sdaOe(sdaOe),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: rtl/regptr_slave_chk.sv
module regptr_slave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sdaOe,
  input logic       sclLvl,
  input logic       startDet,
  input logic       stopDet,
  input logic       wrEn,
  input logic [7:0] ptr
);
  p_oe_rise_scl_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclLvl);

  p_wr_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  p_no_autoinc_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> $stable(ptr));

  p_start_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaOe);

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe);
endmodule

bind regptr_slave regptr_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .sclLvl(sclLvl),
  .startDet(startDet), .stopDet(stopDet), .wrEn(wrEn), .ptr(rdAddr)
);

// File: tb/regptr_slave_tb.sv
module regptr_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] DEV = 7'h4C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic sdaM = 1'b1;
  logic busSda;
  logic sdaOe;
  logic [7:0] rdAddr, rdData, wrAddr, wrData;
  logic wrEn;

  int checks = 0;
  int fails = 0;
  int wrCount = 0;
  int r2Viol = 0;
  logic [7:0] lastAddr = '0, lastData = '0;
  logic oePrev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign busSda = sdaM & ~sdaOe;
  assign rdData = rdAddr ^ 8'hA5;

  regptr_slave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(busSda), .sdaOe(sdaOe),
    .rdAddr(rdAddr), .rdData(rdData), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  always @(negedge clk) begin
    if (wrEn) begin
      wrCount++;
      lastAddr = wrAddr;
      lastData = wrData;
    end
    if (sdaOe !== oePrev && sclIn) r2Viol++;
    oePrev = sdaOe;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic bitXfer(input logic b, output logic s);
    sdaM = b;    waitQ(Q);
    sclIn = 1'b1; waitQ(Q/2);
    s = busSda;  waitQ(Q/2);
    sclIn = 1'b0; waitQ(Q);
  endtask

  task automatic busStart();
    sdaM = 1'b1;  waitQ(Q);
    sclIn = 1'b1; waitQ(Q);
    sdaM = 1'b0;  waitQ(Q);
    sclIn = 1'b0; waitQ(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0;  waitQ(Q);
    sclIn = 1'b1; waitQ(Q);
    sdaM = 1'b1;  waitQ(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bitXfer(b[i], s);
    bitXfer(1'b1, s);
    acked = !s;
  endtask

  task automatic readByte(output logic [7:0] d, output logic slot);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitXfer(1'b1, s);
      d[i] = s;
    end
    bitXfer(1'b1, slot);
  endtask

  task automatic setPtr(input logic [7:0] p);
    logic a;
    busStart();
    sendByte({DEV, 1'b0}, a);
    sendByte(p, a);
    busStop();
  endtask

  task automatic t_reset();
    check(sdaOe == 1'b0, "R10 sdaOe", sdaOe, 0);
    check(rdAddr == 8'h00, "R10 pointer", rdAddr, 0);
    check(wrEn == 1'b0, "R10 wrEn", wrEn, 0);
  endtask

  task automatic t_ptr_only();
    logic a0, a1;
    int w0 = wrCount;
    busStart();
    sendByte({DEV, 1'b0}, a0);
    sendByte(8'h12, a1);
    busStop();
    check(a0, "R3 address ack", a0, 1);
    check(a1, "R4 pointer ack", a1, 1);
    check(rdAddr == 8'h12, "R4 pointer loaded", rdAddr, 8'h12);
    check(wrCount == w0, "R4 no write on pointer-only", wrCount - w0, 0);
  endtask

  task automatic t_ptr_data();
    logic a0, a1, a2;
    int w0 = wrCount;
    busStart();
    sendByte({DEV, 1'b0}, a0);
    sendByte(8'h33, a1);
    sendByte(8'h5A, a2);
    busStop();
    waitQ(2);
    check(a0 && a1 && a2, "R5 acks", {a0, a1, a2}, 3'b111);
    check(wrCount == w0 + 1, "R5 one strobe", wrCount - w0, 1);
    check(lastAddr == 8'h33, "R5 wrAddr", lastAddr, 8'h33);
    check(lastData == 8'h5A, "R5 wrData", lastData, 8'h5A);
    check(sdaOe == 1'b0, "R9 released after stop", sdaOe, 0);
  endtask

  task automatic t_extra_byte();
    logic a0, a1, a2, a3;
    int w0 = wrCount;
    busStart();
    sendByte({DEV, 1'b0}, a0);
    sendByte(8'h40, a1);
    sendByte(8'h01, a2);
    sendByte(8'h02, a3);
    busStop();
    check(a2, "R5 data ack", a2, 1);
    check(!a3, "R6 third byte not acked", a3, 0);
    check(wrCount == w0 + 1, "R6 single strobe", wrCount - w0, 1);
    check(lastData == 8'h01, "R6 data kept", lastData, 8'h01);
    check(rdAddr == 8'h40, "R6 no auto-increment", rdAddr, 8'h40);
  endtask

  task automatic t_read(input logic [7:0] p);
    logic a0, slot;
    logic [7:0] d;
    setPtr(p);
    busStart();
    sendByte({DEV, 1'b1}, a0);
    readByte(d, slot);
    busStop();
    check(a0, "R3 read address ack", a0, 1);
    check(d == (p ^ 8'hA5), "R7 R1 read data MSB first", d, p ^ 8'hA5);
    check(slot == 1'b1, "R7 released in master ack slot", slot, 1);
    check(rdAddr == p, "R7 pointer unchanged by read", rdAddr, p);
  endtask

  task automatic t_mismatch();
    logic a0, a1, slot;
    logic [7:0] d;
    logic [7:0] p0 = rdAddr;
    busStart();
    sendByte({DEV ^ 7'h01, 1'b0}, a0);
    sendByte(8'h77, a1);
    busStop();
    check(!a0, "R3 foreign address not acked", a0, 0);
    check(!a1, "R3 ignored after mismatch", a1, 0);
    check(rdAddr == p0, "R3 pointer kept", rdAddr, p0);
    busStart();
    sendByte({DEV ^ 7'h40, 1'b1}, a0);
    readByte(d, slot);
    busStop();
    check(d == 8'hFF && !a0, "R3 foreign read drives nothing", d, 8'hFF);
  endtask

  task automatic t_restart();
    logic a0, a1, s;
    busStart();
    sendByte({DEV, 1'b0}, a0);
    for (int i = 0; i < 4; i++) bitXfer(i[0], s);
    busStart();
    sendByte({DEV, 1'b0}, a0);
    sendByte(8'h21, a1);
    busStop();
    check(a0, "R8 address ack after restart", a0, 1);
    check(a1, "R8 pointer ack after restart", a1, 1);
    check(rdAddr == 8'h21, "R8 pointer after restart", rdAddr, 8'h21);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    #1;
    t_reset();
    rstN = 1'b1;
    waitQ(4);
    t_ptr_only();
    t_ptr_data();
    t_extra_byte();
    t_read(8'h40);
    t_read(8'hFF);
    t_read(8'h00);
    t_mismatch();
    t_restart();
    check(r2Viol == 0, "R2 drive changes only with clock low", r2Viol, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule